// File: doc/BRIEF.md
# PS/2 Keyboard Start-up Command Sequencer

This block brings a PS/2 keyboard into a known state after power-up. It does not drive the PS/2 lines itself. Instead it hands one command byte at a time to a separate host-to-device transmitter, using a byte bus, a one-cycle load strobe, and the transmitter's busy and error flags. The fixed start-up script runs first. It resets the keyboard to its default settings, then selects scan-code set 2 with a two-byte command. After that it waits for the keyboard to settle and then reports that it is ready.

All waits are measured in pulses of a slow periodic `tick` input, for example a video frame interrupt, and not in clock cycles. Once the block is ready, a request input starts a short two-byte sequence that sets the keyboard indicator lights. Requests that arrive while a sequence is running are remembered and served afterwards. If the transmitter flags an error while a sequence is running, the block stops and holds an error flag.

Top module: `kbd_init_seq`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `tx_load`, `init_done` and `init_error` are 0 and `tx_byte` is 0x00. Every reset restarts the script from its first byte.
- R2: The first byte loaded after reset is 0xF6 (restore keyboard defaults).
- R3: The script then loads 0xF0 and then 0x02 as two separate loads, which selects scan-code set 2.
- R4: After the 0xF6 load and after the 0xF0 load, exactly GAP_TICKS tick pulses (default 2) arrive before the next load. The next load follows one clock after the last of those pulses when the transmitter is idle.
- R5: After the 0x02 load, exactly SETTLE_TICKS tick pulses (default 5) arrive and then `init_done` rises. It rises in the clock after the last pulse and stays high while no error occurs.
- R6: A byte is loaded only while `tx_busy` is low. If `tx_busy` is still high when a wait ends, the load is issued one clock after `tx_busy` is seen low.
- R7: `tx_load` is high for exactly one clock per byte, and `tx_byte` carries that byte in the same cycle.
- R8: After `init_done`, a request sends 0xED and then the argument LED_ARG (default 0x02, bit 1 = Num Lock). GAP_TICKS tick pulses follow each of the two bytes before the next activity.
- R9: A `led_request` pulse that arrives before `init_done`, or during an LED sequence, is held. The LED sequence for a held request starts two clocks after `init_done` rises, or right after the running sequence ends. Several held pulses merge into one sequence.
- R10: If `tx_error` is high while a sequence is running, the block halts. `init_error` goes high and stays high until reset, `init_done` is low, and no further byte is loaded, even if requests arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-clock pulse of the slow timing source |
| tx_busy | input | 1 | Transmitter is sending a byte |
| tx_error | input | 1 | Transmitter reports a failed transfer |
| led_request | input | 1 | Request an indicator-light update |
| tx_byte | output | 8 | Command byte for the transmitter |
| tx_load | output | 1 | One-cycle strobe that hands `tx_byte` to the transmitter |
| init_done | output | 1 | Start-up script has completed |
| init_error | output | 1 | Sticky flag set when a transfer fails |

## Verification
The bench builds the block with its default parameters: two ticks between bytes, five ticks of settling, and Num Lock as the LED argument. With these values the entire script, and two LED sequences after it, fit in a few thousand cycles. Every tick interval between loads is counted exactly and compared with the parameter values. The bench models the transmitter's busy time in two ways. A short busy time finishes inside a gap. A long busy time outlasts the gap, which shows that the load waits for the transmitter. An error injected on the second byte exercises the halt path, followed by a reset that restarts the script.

// File: rtl/kis_pkg.sv
package kis_pkg;

    typedef enum logic [1:0] {
        SQ_ISSUE,   // wait for an idle transmitter, then load
        SQ_WAIT,    // count ticks after a load
        SQ_IDLE,    // script complete, waiting for an LED request
        SQ_HALT     // transmitter failure, frozen until reset
    } sq_state_e;

    typedef struct packed {
        logic [7:0] code;       // byte to hand to the transmitter
        logic       settle;     // wait uses the settle count instead of the gap
        logic       phase_end;  // last byte of its phase
    } step_t;

    localparam logic [7:0] CMD_RESTORE    = 8'hF6;
    localparam logic [7:0] CMD_SELECT_SET = 8'hF0;
    localparam logic [7:0] ARG_SET2       = 8'h02;
    localparam logic [7:0] CMD_SET_LEDS   = 8'hED;

    localparam int STEP_W = 3;
    localparam logic [STEP_W-1:0] STEP_FIRST     = 3'd0;
    localparam logic [STEP_W-1:0] STEP_INIT_LAST = 3'd2;
    localparam logic [STEP_W-1:0] STEP_LED_FIRST = 3'd3;

    function automatic step_t step_lookup(input logic [STEP_W-1:0] idx,
                                          input logic [7:0] led_arg);
        step_t s;
        case (idx)
            3'd0:    s = '{code: CMD_RESTORE,    settle: 1'b0, phase_end: 1'b0};
            3'd1:    s = '{code: CMD_SELECT_SET, settle: 1'b0, phase_end: 1'b0};
            3'd2:    s = '{code: ARG_SET2,       settle: 1'b1, phase_end: 1'b1};
            3'd3:    s = '{code: CMD_SET_LEDS,   settle: 1'b0, phase_end: 1'b0};
            3'd4:    s = '{code: led_arg,        settle: 1'b0, phase_end: 1'b1};
            default: s = '{code: 8'h00,          settle: 1'b0, phase_end: 1'b1};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/kis_tick_timer.sv
module kis_tick_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] target,
    output logic         reached
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // The pulse that completes the count ends the wait in the same clock.
    assign reached = run && tick && (cnt == target - 1'b1);
endmodule

// File: rtl/kis_req_hold.sv
module kis_req_hold (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic take,
    output logic pending
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else begin
            // A request in the cycle it is taken survives as a new one.
            pending <= (pending && !take) || req;
        end
    end
endmodule

// File: rtl/kis_step_rom.sv
module kis_step_rom
    import kis_pkg::*;
#(
    parameter logic [7:0] LED_ARG = 8'h02
) (
    input  logic [STEP_W-1:0] idx,
    output step_t             step
);
    always_comb begin
        step = step_lookup(idx, LED_ARG);
    end
endmodule

// File: rtl/kbd_init_seq.sv
module kbd_init_seq
    import kis_pkg::*;
#(
    parameter int         GAP_TICKS    = 2,
    parameter int         SETTLE_TICKS = 5,
    parameter logic [7:0] LED_ARG      = 8'h02
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       tx_busy,
    input  logic       tx_error,
    input  logic       led_request,
    output logic [7:0] tx_byte,
    output logic       tx_load,
    output logic       init_done,
    output logic       init_error
);
    localparam int TMAX  = (GAP_TICKS > SETTLE_TICKS) ? GAP_TICKS : SETTLE_TICKS;
    localparam int CNT_W = $clog2(TMAX + 1);
    localparam logic [CNT_W-1:0] GAP_T    = CNT_W'(GAP_TICKS);
    localparam logic [CNT_W-1:0] SETTLE_T = CNT_W'(SETTLE_TICKS);

    sq_state_e         state;
    logic [STEP_W-1:0] idx;
    step_t             cur;
    logic              reached;
    logic              pending;
    logic              running;
    logic [CNT_W-1:0]  target;

    kis_step_rom #(.LED_ARG(LED_ARG)) u_rom (
        .idx  (idx),
        .step (cur)
    );

    assign target = cur.settle ? SETTLE_T : GAP_T;

    kis_tick_timer #(.W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (state == SQ_WAIT),
        .tick    (tick),
        .target  (target),
        .reached (reached)
    );

    kis_req_hold u_req (
        .clk     (clk),
        .rst     (rst),
        .req     (led_request),
        .take    (state == SQ_IDLE),
        .pending (pending)
    );

    assign running = (state == SQ_ISSUE) || (state == SQ_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SQ_ISSUE;
            idx        <= STEP_FIRST;
            tx_byte    <= 8'h00;
            tx_load    <= 1'b0;
            init_done  <= 1'b0;
            init_error <= 1'b0;
        end else begin
            tx_load <= 1'b0;
            if (running && tx_error) begin
                state      <= SQ_HALT;
                init_error <= 1'b1;
                init_done  <= 1'b0;
            end else begin
                case (state)
                    SQ_ISSUE: begin
                        if (!tx_busy) begin
                            tx_byte <= cur.code;
                            tx_load <= 1'b1;
                            state   <= SQ_WAIT;
                        end
                    end
                    SQ_WAIT: begin
                        if (reached) begin
                            if (cur.phase_end) begin
                                if (idx == STEP_INIT_LAST) begin
                                    init_done <= 1'b1;
                                end
                                state <= SQ_IDLE;
                            end else begin
                                idx   <= idx + 1'b1;
                                state <= SQ_ISSUE;
                            end
                        end
                    end
                    SQ_IDLE: begin
                        if (pending) begin
                            idx   <= STEP_LED_FIRST;
                            state <= SQ_ISSUE;
                        end
                    end
                    default: begin
                        state <= SQ_HALT;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/kbd_init_seq_chk.sv
module kbd_init_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       tx_busy,
    input logic       tx_error,
    input logic [7:0] tx_byte,
    input logic       tx_load,
    input logic       init_done,
    input logic       init_error
);
    logic seen_load;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_load <= 1'b0;
        end else if (tx_load) begin
            seen_load <= 1'b1;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!tx_load && !init_done && !init_error && tx_byte == 8'h00));

    // R2
    first_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_load && !seen_load) |-> (tx_byte == 8'hF6));

    // R5
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (init_done && !tx_error) |=> init_done);

    // R6
    load_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_load) |-> $past(!tx_busy));

    // R7
    load_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tx_load |=> !tx_load);

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        init_error |=> init_error);

    // R10
    err_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(init_done && init_error));

    // R10
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        init_error |-> !tx_load);
endmodule

bind kbd_init_seq kbd_init_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tx_busy    (tx_busy),
    .tx_error   (tx_error),
    .tx_byte    (tx_byte),
    .tx_load    (tx_load),
    .init_done  (init_done),
    .init_error (init_error)
);

// File: tb/tb_kbd_init_seq.sv
`timescale 1ns/1ps
module tb_kbd_init_seq;
    localparam int TICK_DIV = 50;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       tx_busy = 1'b0;
    logic       tx_error = 1'b0;
    logic       led_request = 1'b0;
    logic [7:0] tx_byte;
    logic       tx_load;
    logic       init_done;
    logic       init_error;

    always #2.5 clk = ~clk;

    kbd_init_seq dut (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .tx_busy     (tx_busy),
        .tx_error    (tx_error),
        .led_request (led_request),
        .tx_byte     (tx_byte),
        .tx_load     (tx_load),
        .init_done   (init_done),
        .init_error  (init_error)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ticks_since = 0;
    int nlog = 0;
    logic [7:0] log_b [64];
    int log_gap [64];
    int log_cyc [64];
    int log_blow [64];
    int done_gap = -1;
    int done_cyc = -1;
    logic done_prev = 1'b0;
    logic load_prev = 1'b0;
    int double_loads = 0;
    int busy_cnt = 0;
    int busy_low_cyc = 0;
    int long_idx = -1;
    int err_at = -1;
    int tick_div = 0;
    logic finished = 1'b0;

    // Transmitter and tick model plus load monitor, all away from the active edge.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (tx_load && load_prev) double_loads = double_loads + 1;
        load_prev = tx_load;
        if (tx_load) begin
            if (nlog < 64) begin
                log_b[nlog]    = tx_byte;
                log_gap[nlog]  = ticks_since;
                log_cyc[nlog]  = cyc;
                log_blow[nlog] = busy_low_cyc;
            end
            busy_cnt = (nlog == long_idx) ? 130 : 8;
            tx_busy = 1'b1;
            if (nlog == err_at) tx_error = 1'b1;
            nlog = nlog + 1;
            ticks_since = 0;
        end else begin
            if (tick) ticks_since = ticks_since + 1;
            if (busy_cnt > 0) begin
                busy_cnt = busy_cnt - 1;
                if (busy_cnt == 0) begin
                    tx_busy = 1'b0;
                    busy_low_cyc = cyc;
                end
            end
        end
        if (init_done && !done_prev) begin
            done_gap = ticks_since;
            done_cyc = cyc;
        end
        done_prev = init_done;
        tick_div = (tick_div + 1) % TICK_DIV;
        tick = (tick_div == 0);
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        tx_error = 1'b0;
        repeat (3) @(negedge clk);
        nlog = 0;
        done_gap = -1;
        done_cyc = -1;
        double_loads = 0;
        rst = 1'b0;
    endtask

    task automatic pulse_req();
        @(negedge clk);
        led_request = 1'b1;
        @(negedge clk);
        led_request = 1'b0;
    endtask

    task automatic wait_loads(input int n, input string req);
        for (int i = 0; i < 3000 && nlog < n; i++) @(negedge clk);
        chk(req, nlog, n);
    endtask

    initial begin
        // ---------- run 1: script, held request, merged requests ----------
        repeat (3) @(negedge clk);
        chk("R1 tx_load in reset", int'(tx_load), 0);
        chk("R1 init_done in reset", int'(init_done), 0);
        chk("R1 init_error in reset", int'(init_error), 0);
        chk("R1 tx_byte in reset", int'(tx_byte), 0);
        nlog = 0;
        rst = 1'b0;
        pulse_req();                       // R9: arrives before init_done
        wait_loads(5, "R9 held request served");
        chk("R2 first byte", int'(log_b[0]), 8'hF6);
        chk("R3 second byte", int'(log_b[1]), 8'hF0);
        chk("R3 third byte", int'(log_b[2]), 8'h02);
        chk("R4 gap after F6", log_gap[1], 2);
        chk("R4 gap after F0", log_gap[2], 2);
        chk("R5 settle ticks", done_gap, 5);
        chk("R5 init_done high", int'(init_done), 1);
        chk("R9 start two clocks after done", log_cyc[3] - done_cyc, 2);
        chk("R8 LED command", int'(log_b[3]), 8'hED);
        chk("R8 LED argument", int'(log_b[4]), 8'h02);
        chk("R8 gap after ED", log_gap[4], 2);
        repeat (20) @(negedge clk);
        pulse_req();                       // R9: two pulses during LED sequence
        repeat (15) @(negedge clk);
        pulse_req();
        wait_loads(7, "R9 request during sequence");
        chk("R8 gap after argument", log_gap[5], 2);
        chk("R8 repeat command", int'(log_b[5]), 8'hED);
        chk("R8 repeat argument", int'(log_b[6]), 8'h02);
        repeat (600) @(negedge clk);
        chk("R9 merged requests", nlog, 7);
        chk("R5 done stays", int'(init_done), 1);
        chk("R10 no error", int'(init_error), 0);
        chk("R7 single-cycle loads", double_loads, 0);

        // ---------- run 2: transmitter busy longer than the gap ----------
        long_idx = 1;
        do_reset();
        wait_loads(3, "R6 script with long busy");
        chk("R6 load one clock after busy low", log_cyc[2] - log_blow[2], 1);
        chk("R4 gap under long busy", log_gap[2], 2);
        chk("R3 byte after long busy", int'(log_b[2]), 8'h02);
        long_idx = -1;

        // ---------- run 3: transmitter error ----------
        err_at = 1;
        do_reset();
        repeat (800) @(negedge clk);
        chk("R10 loads stop", nlog, 2);
        chk("R10 init_error set", int'(init_error), 1);
        chk("R10 init_done low", int'(init_done), 0);
        pulse_req();
        repeat (400) @(negedge clk);
        chk("R10 request ignored", nlog, 2);
        chk("R10 error sticky", int'(init_error), 1);
        err_at = -1;
        do_reset();
        @(negedge clk);
        chk("R1 error cleared", int'(init_error), 0);
        wait_loads(1, "R1 restart");
        chk("R1 script restarts", int'(log_b[0]), 8'hF6);
        chk("R7 single-cycle loads", double_loads, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule